// File: doc/BRIEF.md
# Serial Memory Two-Wire Slave Engine

This block is the bus-facing half of a 128-byte serial memory. It watches the two wires of an I2C bus with a fast system clock, cleans both lines through a synchronizer and a glitch filter, and recognises Start and Stop. It receives a control byte that carries a fixed device code, then a word address and write data. It answers with acknowledge pulses and, for reads, shifts memory bytes out through an open-drain enable.

Behind it sits a separate page-write controller that sees only byte-level events: an address load, a data strobe for each written byte and a Stop pulse. It returns a busy level while it programs the array. While that busy level is high the engine stays silent on the bus. Reads come straight from the array through a combinational read port addressed by the engine's own pointer.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset `sdaOe` is low and no strobe is active; every Stop (SDA rising while SCL high) gives one single-cycle `stopEvent` pulse and leaves `sdaOe` low.
- R2: A control byte is acknowledged only when its bits 7..4 are 1010, whatever bits 3..1 hold; any other code gets no acknowledge, and the engine then ignores every byte until the next Start.
- R3: A received byte that is accepted is acknowledged by holding SDA low for the whole high phase of the ninth SCL pulse.
- R4: In a write (control bit 0 = 0), the next byte is the word address; bit 7 is dropped, `addrLoad` pulses once with `addrValue` = bits 6..0, and the pointer takes that value.
- R5: Each further byte of a write is acknowledged and gives one `dataStrobe` pulse with the byte on `dataValue`; the pointer then advances by one.
- R6: While `writeBusy` is high no byte is acknowledged, the control byte included, and no `addrLoad` or `dataStrobe` is issued.
- R7: A read (control bit 0 = 1) returns the byte at the pointer; the pointer advances after each byte sent, wrapping from 0x7F to 0x00.
- R8: A write control byte and word address followed by a repeated Start and a read control byte make the read begin at that word address.
- R9: When the master leaves SDA high in the ninth pulse after a read byte, the engine sends nothing more and keeps SDA released.
- R10: The engine changes `sdaOe` only while SCL is low, at least `HOLD_CYCLES` system clocks after SCL falls, except the release forced by Start or Stop.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect.
- R12: A Start in the middle of a byte drops that byte and starts control-byte reception afresh.
- R13: Read data leaves the engine most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |
| writeBusy | input | 1 | High while the page-write controller programs the array |
| addrLoad | output | 1 | One-cycle pulse: a word address was received |
| addrValue | output | ADDR_W | Word address that goes with `addrLoad` |
| dataStrobe | output | 1 | One-cycle pulse: a write data byte was received |
| dataValue | output | 8 | Data byte that goes with `dataStrobe` |
| stopEvent | output | 1 | One-cycle pulse on each Stop |
| rdAddr | output | ADDR_W | Array read address (the engine's pointer) |
| rdData | input | 8 | Array byte at `rdAddr`, combinational |

## Verification
The bench sweeps all sixteen device-code nibbles with varying select bits. An engine that decoded the wrong field would acknowledge a foreign code, and one that never went deaf after a refusal would load the byte that follows it as an address. A sequential read is started four bytes before the top of the array, so a pointer that saturates or overflows into an eighth bit shows up as a wrong byte after 0x7F. Two-cycle spikes are placed on SCL inside a low phase and on SDA inside a high phase. A filter that is too short counts an extra bit or sees a false Stop, and either one corrupts the strobed byte. A Start after half a control byte checks that a leftover bit count does not shift the next frame. The stretch between each SCL fall and every change of the engine's drive is timed, to catch a drive that moves too soon after the fall.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  localparam int BYTE_W = 8;
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_TX
  } linkState_t;

  typedef enum logic [1:0] {
    BK_CTRL,
    BK_ADDR,
    BK_DATA
  } byteKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       shiftIn;
    logic       capture;
    logic       loadPtr;
    logic       incPtr;
    logic       loadTx;
    logic       driveAck;
    logic       driveRel;
    logic       driveBit;
    logic [2:0] bitSel;
    logic       releaseNow;
  } dpCtl_t;

endpackage

// File: rtl/line_conditioner.sv
module line_conditioner #(
  parameter int FILT_LEN = 3,
  parameter int LINES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]    syncQ;
    logic [CW-1:0] agreeCnt;
    logic          lvl;
    logic          lvlPrev;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ    <= 2'b11;
        agreeCnt <= '0;
        lvl      <= 1'b1;
        lvlPrev  <= 1'b1;
      end else begin
        syncQ   <= {syncQ[0], rawIn[g]};
        lvlPrev <= lvl;
        if (syncQ[1] == lvl) begin
          agreeCnt <= '0;
        end else if (agreeCnt == CW'(FILT_LEN - 1)) begin
          lvl      <= syncQ[1];
          agreeCnt <= '0;
        end else begin
          agreeCnt <= agreeCnt + 1'b1;
        end
      end
    end

    assign level[g] = lvl;
    assign rise[g]  = lvl & ~lvlPrev;
    assign fall[g]  = ~lvl & lvlPrev;
  end

endmodule

// File: rtl/slave_datapath.sv
module slave_datapath
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic [BYTE_W-1:0] lastByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              pendValid;
  logic              pendVal;
  logic [HW-1:0]     holdCnt;
  logic              sched;
  logic              schedVal;

  assign rxNext = {rxShift[BYTE_W-2:0], sdaLvl};

  always_comb begin
    sched    = 1'b1;
    schedVal = 1'b0;
    if (ctl.loadTx)        schedVal = ~rdData[BYTE_W-1];
    else if (ctl.driveBit) schedVal = ~txShift[ctl.bitSel];
    else if (ctl.driveAck) schedVal = 1'b1;
    else if (ctl.driveRel) schedVal = 1'b0;
    else                   sched    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      lastByte <= '0;
      ptr      <= '0;
    end else begin
      if (ctl.shiftIn) rxShift  <= rxNext;
      if (ctl.capture) lastByte <= rxNext;
      if (ctl.loadTx)  txShift  <= rdData;
      if (ctl.loadPtr)                  ptr <= rxNext[ADDR_W-1:0];
      else if (ctl.incPtr | ctl.loadTx) ptr <= ptr + 1'b1;
    end
  end

  // drive changes wait HOLD_CYCLES after the SCL fall that scheduled them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe     <= 1'b0;
      pendValid <= 1'b0;
      pendVal   <= 1'b0;
      holdCnt   <= '0;
    end else if (ctl.releaseNow) begin
      sdaOe     <= 1'b0;
      pendValid <= 1'b0;
    end else if (sched) begin
      pendValid <= 1'b1;
      pendVal   <= schedVal;
      holdCnt   <= HW'(HOLD_CYCLES);
    end else if (pendValid) begin
      if (holdCnt == '0) begin
        sdaOe     <= pendVal;
        pendValid <= 1'b0;
      end else begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/slave_control.sv
module slave_control
  import serial_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [3:0] devCode,
  input  logic       rwBit,
  input  logic       writeBusy,
  output dpCtl_t     ctl,
  output logic       addrLoad,
  output logic       dataStrobe,
  output logic       stopEvent
);

  linkState_t state, stateN;
  byteKind_t  kind, kindN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackPlan, ackPlanN;
  logic       isRead, isReadN;
  logic       mAck, mAckN;
  logic       addrLoadN, dataStrobeN, stopEventN;
  logic [3:0] selCalc;

  assign selCalc = 4'd7 - bitCnt;

  always_comb begin
    ctl         = '0;
    stateN      = state;
    kindN       = kind;
    bitCntN     = bitCnt;
    ackPlanN    = ackPlan;
    isReadN     = isRead;
    mAckN       = mAck;
    addrLoadN   = 1'b0;
    dataStrobeN = 1'b0;
    stopEventN  = 1'b0;

    if (stopDet) begin
      stateN         = ST_IDLE;
      ctl.releaseNow = 1'b1;
      stopEventN     = 1'b1;
    end else if (startDet) begin
      stateN         = ST_RX;
      kindN          = BK_CTRL;
      bitCntN        = '0;
      ackPlanN       = 1'b0;
      isReadN        = 1'b0;
      ctl.releaseNow = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            if (bitCnt < 4'd8) begin
              ctl.shiftIn = 1'b1;
              bitCntN     = bitCnt + 1'b1;
              if (bitCnt == 4'd7) begin
                if (writeBusy || (kind == BK_CTRL && devCode != DEV_CODE)) begin
                  stateN = ST_IDLE;
                end else begin
                  ackPlanN    = 1'b1;
                  ctl.capture = 1'b1;
                  unique case (kind)
                    BK_CTRL: begin
                      isReadN = rwBit;
                      kindN   = BK_ADDR;
                    end
                    BK_ADDR: begin
                      ctl.loadPtr = 1'b1;
                      addrLoadN   = 1'b1;
                      kindN       = BK_DATA;
                    end
                    default: begin
                      ctl.incPtr  = 1'b1;
                      dataStrobeN = 1'b1;
                    end
                  endcase
                end
              end
            end else if (bitCnt == 4'd8) begin
              bitCntN = 4'd9;
            end
          end else if (sclFall) begin
            if (bitCnt == 4'd8 && ackPlan) begin
              ctl.driveAck = 1'b1;
            end else if (bitCnt == 4'd9) begin
              bitCntN  = '0;
              ackPlanN = 1'b0;
              if (isRead) begin
                ctl.loadTx = 1'b1;
                stateN     = ST_TX;
              end else begin
                ctl.driveRel = 1'b1;
              end
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            if (bitCnt < 4'd8) begin
              bitCntN = bitCnt + 1'b1;
            end else if (bitCnt == 4'd8) begin
              mAckN   = ~sdaLvl;
              bitCntN = 4'd9;
            end
          end else if (sclFall) begin
            if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
              ctl.driveBit = 1'b1;
              ctl.bitSel   = selCalc[2:0];
            end else if (bitCnt == 4'd8) begin
              ctl.driveRel = 1'b1;
            end else if (bitCnt == 4'd9) begin
              if (mAck) begin
                ctl.loadTx = 1'b1;
                bitCntN    = '0;
              end else begin
                stateN = ST_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= BK_CTRL;
      bitCnt     <= '0;
      ackPlan    <= 1'b0;
      isRead     <= 1'b0;
      mAck       <= 1'b0;
      addrLoad   <= 1'b0;
      dataStrobe <= 1'b0;
      stopEvent  <= 1'b0;
    end else begin
      state      <= stateN;
      kind       <= kindN;
      bitCnt     <= bitCntN;
      ackPlan    <= ackPlanN;
      isRead     <= isReadN;
      mAck       <= mAckN;
      addrLoad   <= addrLoadN;
      dataStrobe <= dataStrobeN;
      stopEvent  <= stopEventN;
    end
  end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int HOLD_CYCLES = 16,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              writeBusy,
  output logic              addrLoad,
  output logic [ADDR_W-1:0] addrValue,
  output logic              dataStrobe,
  output logic [BYTE_W-1:0] dataValue,
  output logic              stopEvent,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData
);

  logic [1:0]        lineLvl, lineRise, lineFall;
  logic              sclLvl, sdaLvl;
  logic              startDet, stopDet;
  dpCtl_t            ctl;
  logic [BYTE_W-1:0] rxNext;
  logic [BYTE_W-1:0] lastByte;

  line_conditioner #(.FILT_LEN(FILT_LEN), .LINES(2)) u_lines (
    .clk  (clk),
    .rstN (rstN),
    .rawIn({sdaIn, sclIn}),
    .level(lineLvl),
    .rise (lineRise),
    .fall (lineFall)
  );

  assign sclLvl   = lineLvl[SCL_IDX];
  assign sdaLvl   = lineLvl[SDA_IDX];
  assign startDet = lineFall[SDA_IDX] & sclLvl;
  assign stopDet  = lineRise[SDA_IDX] & sclLvl;

  slave_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (lineRise[SCL_IDX]),
    .sclFall   (lineFall[SCL_IDX]),
    .sdaLvl    (sdaLvl),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .devCode   (rxNext[7:4]),
    .rwBit     (rxNext[0]),
    .writeBusy (writeBusy),
    .ctl       (ctl),
    .addrLoad  (addrLoad),
    .dataStrobe(dataStrobe),
    .stopEvent (stopEvent)
  );

  slave_datapath #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .sdaLvl  (sdaLvl),
    .rdData  (rdData),
    .rxNext  (rxNext),
    .lastByte(lastByte),
    .ptr     (rdAddr),
    .sdaOe   (sdaOe)
  );

  assign addrValue = lastByte[ADDR_W-1:0];
  assign dataValue = lastByte;

endmodule

// File: rtl/serial_mem_slave_checker.sv
module serial_mem_slave_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              startDet,
  input logic              stopDet,
  input logic              sdaOe,
  input logic              writeBusy,
  input logic              addrLoad,
  input logic              dataStrobe,
  input logic              stopEvent,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] addrValue
);

  // R10: the drive is asserted only during SCL low
  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLvl);

  // R10: a release outside Start/Stop also happens only during SCL low
  p_oe_fall_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !$past(startDet || stopDet)) |-> !sclLvl);

  // R6: no byte events follow a cycle with busy high
  p_busy_no_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad || dataStrobe) |-> !$past(writeBusy));

  // R5: byte-level events never overlap
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrLoad, dataStrobe, stopEvent}));

  // R1: SDA is released when the Stop pulse appears
  p_stop_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEvent |-> !sdaOe);

  // R4: the read pointer takes the delivered word address
  p_ptr_follows_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |-> (rdAddr == addrValue));

endmodule

bind serial_mem_slave serial_mem_slave_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sclLvl    (sclLvl),
  .startDet  (startDet),
  .stopDet   (stopDet),
  .sdaOe     (sdaOe),
  .writeBusy (writeBusy),
  .addrLoad  (addrLoad),
  .dataStrobe(dataStrobe),
  .stopEvent (stopEvent),
  .rdAddr    (rdAddr),
  .addrValue (addrValue)
);

// File: tb/serial_mem_slave_bench.sv
module serial_mem_slave_bench;

  localparam int Q    = 20;
  localparam int HOLD = 16;
  localparam int FILT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       writeBusy = 1'b0;
  logic       sdaOe, addrLoad, dataStrobe, stopEvent;
  logic [6:0] addrValue, rdAddr;
  logic [7:0] dataValue, rdData;
  wire        sdaBus = mSda & ~sdaOe;

  function automatic logic [7:0] memVal(input logic [6:0] a);
    return 8'(int'(a) * 37 + 11);
  endfunction

  assign rdData = memVal(rdAddr);

  serial_mem_slave #(.FILT_LEN(FILT), .HOLD_CYCLES(HOLD), .ADDR_W(7)) u_serial_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .writeBusy(writeBusy), .addrLoad(addrLoad), .addrValue(addrValue),
    .dataStrobe(dataStrobe), .dataValue(dataValue), .stopEvent(stopEvent),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int nChecks = 0, nFails = 0;
  int addrCnt = 0, dataCnt = 0, stopCnt = 0, oeChanges = 0, holdViol = 0, sinceFall = 0;
  logic [6:0] lastAddr = '0;
  logic [7:0] dataLog [16];
  logic prevOe = 1'b0, prevScl = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (addrLoad) begin addrCnt++; lastAddr = addrValue; end
      if (dataStrobe) begin
        if (dataCnt < 16) dataLog[dataCnt] = dataValue;
        dataCnt++;
      end
      if (stopEvent) stopCnt++;
      if (!mScl && prevScl) sinceFall = 0;
      else if (!mScl) sinceFall++;
      if (sdaOe != prevOe) begin
        oeChanges++;
        if (mScl || sinceFall < HOLD) holdViol++;
      end
    end
    prevOe  = sdaOe;
    prevScl = mScl;
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b0; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic busStop();
    mSda = 1'b0; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b1; qwait();
  endtask

  task automatic clockBit(input bit b, input bit gScl, input bit gSda,
                          output bit smp, output bit steady);
    bit a, z;
    mSda = b;
    if (gScl) begin
      repeat (4) @(negedge clk); mScl = 1'b1;
      repeat (FILT - 1) @(negedge clk); mScl = 1'b0;
      repeat (Q - 4 - (FILT - 1)) @(negedge clk);
    end else qwait();
    mScl = 1'b1;
    a = sdaBus;
    if (gSda) begin
      repeat (4) @(negedge clk); mSda = ~b;
      repeat (FILT - 1) @(negedge clk); mSda = b;
      repeat (Q - 4 - (FILT - 1)) @(negedge clk);
    end else qwait();
    smp = sdaBus;
    qwait();
    z = sdaBus;
    steady = (a == smp) && (smp == z);
    mScl = 1'b0;
    qwait();
  endtask

  task automatic sendByte(input logic [7:0] v, input int gs, input int gd,
                          output bit ack, output bit steady);
    bit s, st;
    for (int i = 7; i >= 0; i--) clockBit(v[i], i == gs, i == gd, s, st);
    clockBit(1'b1, 1'b0, 1'b0, s, steady);
    ack = !s;
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] v);
    bit s, st;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 1'b0, 1'b0, s, st);
      v[i] = s;
    end
    clockBit(!mack, 1'b0, 1'b0, s, st);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    bit ack, ack2, st;
    logic [7:0] v;
    int base, d0, s0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sdaOe && !addrLoad && !dataStrobe && !stopEvent, "R1 reset outputs",
          {sdaOe, addrLoad, dataStrobe, stopEvent}, 0);

    // R2 sweep of every device-code nibble
    for (int nib = 0; nib < 16; nib++) begin
      busStart();
      sendByte({nib[3:0], 3'(nib), 1'b0}, -1, -1, ack, st);
      check(ack == (nib == 10), "R2 control ack", ack, nib == 10);
      base = addrCnt;
      sendByte(8'h33, -1, -1, ack2, st);
      check(ack2 == (nib == 10) && addrCnt == base + int'(nib == 10),
            "R2 byte after control", addrCnt - base, nib == 10);
      busStop();
    end
    check(stopCnt == 16, "R1 stop pulses", stopCnt, 16);
    check(lastAddr == 7'h33, "R4 sweep address", lastAddr, 8'h33);

    // byte write, address bit 7 set
    busStart();
    sendByte(8'hA6, -1, -1, ack, st);
    sendByte(8'h95, -1, -1, ack, st);
    check(ack && lastAddr == 7'h15, "R4 address bit7 dropped", lastAddr, 8'h15);
    d0 = dataCnt;
    sendByte(8'hC3, -1, -1, ack, st);
    check(ack && st, "R3 ack held through high phase", {ack, st}, 3);
    check(dataCnt == d0 + 1 && dataLog[d0] == 8'hC3, "R5 byte write strobe", dataLog[d0], 8'hC3);
    busStop();
    check(stopCnt == 17, "R1 stop after write", stopCnt, 17);

    // page of three bytes
    busStart();
    sendByte(8'hA0, -1, -1, ack, st);
    sendByte(8'h40, -1, -1, ack, st);
    d0 = dataCnt;
    for (int k = 0; k < 3; k++) sendByte(8'h10 + 8'(k), -1, -1, ack, st);
    for (int k = 0; k < 3; k++)
      check(dataLog[d0 + k] == 8'h10 + 8'(k), "R5 page strobe", dataLog[d0 + k], 8'h10 + k);
    check(dataCnt == d0 + 3, "R5 strobe count", dataCnt - d0, 3);
    busStop();

    // random read across the top of the array
    busStart();
    sendByte(8'hA0, -1, -1, ack, st);
    sendByte(8'h7C, -1, -1, ack, st);
    busStart();
    sendByte(8'hA1, -1, -1, ack, st);
    check(ack, "R8 read control ack", ack, 1);
    for (int k = 0; k < 6; k++) begin
      recvByte(k != 5, v);
      check(v == memVal(7'(8'h7C + k)), "R7 R8 R13 read byte", v, memVal(7'(8'h7C + k)));
    end
    qwait(); qwait();
    check(!sdaOe, "R9 released after master nack", sdaOe, 0);
    busStop();

    // current-address read continues after wrap
    busStart();
    sendByte(8'hA1, -1, -1, ack, st);
    recvByte(1'b1, v);
    check(v == memVal(7'h02), "R7 current read first", v, memVal(7'h02));
    recvByte(1'b0, v);
    check(v == memVal(7'h03), "R7 current read second", v, memVal(7'h03));
    busStop();

    // busy: silent, no events
    writeBusy = 1'b1;
    base = addrCnt;
    busStart();
    sendByte(8'hA0, -1, -1, ack, st);
    check(!ack, "R6 write control while busy", ack, 0);
    sendByte(8'h05, -1, -1, ack, st);
    check(!ack && addrCnt == base, "R6 no address while busy", addrCnt - base, 0);
    busStop();
    busStart();
    sendByte(8'hA1, -1, -1, ack, st);
    check(!ack, "R6 read control while busy", ack, 0);
    busStop();
    writeBusy = 1'b0;

    // glitches on both lines
    busStart();
    sendByte(8'hA0, -1, -1, ack, st);
    sendByte(8'h10, -1, -1, ack, st);
    d0 = dataCnt; s0 = stopCnt;
    sendByte(8'hA5, 3, 6, ack, st);
    check(ack && dataCnt == d0 + 1 && dataLog[d0] == 8'hA5, "R11 spikes ignored", dataLog[d0], 8'hA5);
    check(stopCnt == s0, "R11 no false stop", stopCnt - s0, 0);
    busStop();

    // Start in the middle of a byte
    busStart();
    for (int i = 0; i < 4; i++) clockBit(i[0] == 1'b0, 1'b0, 1'b0, ack, st);
    busStart();
    sendByte(8'hA0, -1, -1, ack, st);
    check(ack, "R12 control after abort", ack, 1);
    sendByte(8'h22, -1, -1, ack, st);
    check(lastAddr == 7'h22, "R12 address after abort", lastAddr, 8'h22);
    d0 = dataCnt;
    sendByte(8'h5A, -1, -1, ack, st);
    check(dataLog[d0] == 8'h5A, "R12 data after abort", dataLog[d0], 8'h5A);
    busStop();
    busStart();
    sendByte(8'hA1, -1, -1, ack, st);
    recvByte(1'b0, v);
    check(v == memVal(7'h23), "R7 pointer after write", v, memVal(7'h23));
    busStop();

    check(holdViol == 0 && oeChanges > 0, "R10 drive timing", holdViol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule